// File: doc/BRIEF.md
# MDIO Command Register Controller

This block is a management-bus master for Ethernet PHYs, driven by one 32-bit command word. A requester writes the word; the block decodes it into a read or write request, a 5-bit PHY address, a 5-bit register address, a bus selector and (for writes) 16 bits of payload. It then shifts a standard Clause 22 management frame out on one of two clock/data pin pairs: one pair serves on-die PHYs, the other serves PHYs outside the chip.

Commands are armed by writing zero first. A non-zero word is accepted only when the command register currently holds zero and no frame is running. Writing zero during a frame aborts it at once. The block raises `busy_o` for the whole frame and `done_o` after a frame completes normally. The 16 bits returned by a read are latched into a data output that holds until the next completed read. The requester may simply wait a fixed interval and then read the data. With the default divider the frame fits well inside a 50 µs budget at a 100 MHz system clock.

Top module: `mdio_cmd_ctrl`

## Requirements
- R1: After reset `busy_o`, `done_o` and `rdata_o` are 0, both management clocks are low and both data enables are low.
- R2: Command word fields are read bit 31, write bit 30, external-bus select bit 26, PHY address bits 25:21, register address bits 20:16 and write data bits 15:0. A non-zero word with bit 31 or bit 30 set starts a frame when the register holds zero and no frame runs; `busy_o` is high from the next cycle. If both bits are set the frame is a read.
- R3: A non-zero write while the register holds a non-zero word is ignored, whether or not a frame is running. No new frame starts and a running frame continues unchanged.
- R4: A zero write during a frame aborts it. From the next cycle `busy_o` and `done_o` are low, both clocks are low, both enables are low and `rdata_o` is unchanged. The next command then runs normally.
- R5: The frame on the pins is, MSB first: 32 ones, 01, opcode 10 (read) or 01 (write), PHY address, register address, then turnaround. On writes the turnaround is driven as 10 and followed by the 16 data bits. On reads the enable is low for the turnaround and data slots. Driven bits change only while the clock is low.
- R6: The management clock is low for HALF_DIV system cycles and then high for HALF_DIV cycles per bit (default 20). There are exactly 64 rising edges per frame, and the clock is low when idle.
- R7: On reads the line is sampled at each clock rising edge of the 16 data slots, MSB first, and latched into `rdata_o` when the frame ends. A line nobody drives, which is pulled high, returns 0xFFFF.
- R8: `busy_o` stays high for exactly 2·HALF_DIV·64 system cycles (2560 by default, 25.6 µs at 100 MHz, inside the 50 µs budget).
- R9: `done_o` rises when a frame completes normally and is cleared by any zero write or by the next accepted command.
- R10: Bit 26 = 1 selects the external pair and 0 the internal pair. The other pair keeps its clock low and its enable low throughout the frame.
- R11: Write frames leave `rdata_o` unchanged.
- R12: A non-zero word with neither bit 31 nor bit 30 set is stored but starts no frame. Until a zero write follows it, further commands are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_we_i | input | 1 | Command register write strobe |
| cmd_wdata_i | input | 32 | Command word |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | Last frame completed normally |
| rdata_o | output | 16 | Latched read data |
| int_mdc_o | output | 1 | Internal-bus management clock |
| int_mdio_o | output | 1 | Internal-bus data out |
| int_mdio_oe_o | output | 1 | Internal-bus data enable |
| int_mdio_i | input | 1 | Internal-bus data in |
| ext_mdc_o | output | 1 | External-bus management clock |
| ext_mdio_o | output | 1 | External-bus data out |
| ext_mdio_oe_o | output | 1 | External-bus data enable |
| ext_mdio_i | input | 1 | External-bus data in |

## Verification
A behavioural PHY on each pair captures every bit at the clock rising edges and drives read data after falling edges. A serializer off by one slot, or with a wrong turnaround, fails the frame comparison. A sampler on the wrong edge returns shifted read data. The bench writes a second command in mid-frame, and re-arms without a zero write; a design that rearms too eagerly would corrupt the frame or start a spurious one. Further cases are a zero-write abort, a word with no request flags and a word with both flags. A wrong bus select, or a leaky inactive pair, shows up as edges on the wrong pins, and an undriven read must return all ones.

// File: rtl/mdio_cmd_pkg.sv
package mdio_cmd_pkg;
  localparam int unsigned CMD_W      = 32;
  localparam int unsigned RD_BIT     = 31;
  localparam int unsigned WR_BIT     = 30;
  localparam int unsigned EXT_BIT    = 26;
  localparam int unsigned ADDR_W     = 5;
  localparam int unsigned PHY_LSB    = 21;
  localparam int unsigned REG_LSB    = 16;
  localparam int unsigned DATA_W     = 16;
  // start + opcode + two addresses + turnaround + data
  localparam int unsigned FIXED_BITS = 4 + 2 * ADDR_W + 2 + DATA_W;
  localparam int unsigned NUM_BUS    = 2;

  typedef enum logic [1:0] {
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10
  } mdio_op_e;

  typedef struct packed {
    logic              rd;
    logic              wr;
    logic              ext;
    logic [ADDR_W-1:0] phy;
    logic [ADDR_W-1:0] regad;
    logic [DATA_W-1:0] wdata;
  } mdio_cmd_t;

  function automatic mdio_cmd_t decode_cmd(input logic [CMD_W-1:0] w);
    mdio_cmd_t c;
    c.rd    = w[RD_BIT];
    c.wr    = w[WR_BIT];
    c.ext   = w[EXT_BIT];
    c.phy   = w[PHY_LSB +: ADDR_W];
    c.regad = w[REG_LSB +: ADDR_W];
    c.wdata = w[DATA_W-1:0];
    return c;
  endfunction
endpackage

// File: rtl/mdio_cmd_reg.sv
module mdio_cmd_reg
  import mdio_cmd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CMD_W-1:0] wdata_i,
  input  logic             busy_i,
  output logic             start_o,
  output logic             cancel_o,
  output logic             clear_o,
  output mdio_cmd_t        start_cmd_o,
  output mdio_cmd_t        cur_cmd_o
);
  logic [CMD_W-1:0] cmd_q;
  logic             wr_zero;
  logic             armed;

  assign wr_zero     = (wdata_i == '0);
  assign armed       = (cmd_q == '0) && !busy_i;
  assign start_cmd_o = decode_cmd(wdata_i);
  assign cur_cmd_o   = decode_cmd(cmd_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= '0;
    end else if (we_i) begin
      if (wr_zero)    cmd_q <= '0;
      else if (armed) cmd_q <= wdata_i;
    end
  end

  assign start_o  = we_i && !wr_zero && armed && (start_cmd_o.rd || start_cmd_o.wr);
  assign cancel_o = we_i && wr_zero && busy_i;
  assign clear_o  = we_i && wr_zero;

  a_r3_hold_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !wr_zero && cmd_q != '0) |=> $stable(cmd_q));
endmodule

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int unsigned HALF_DIV   = 20,
  parameter int unsigned FRAME_BITS = 64,
  localparam int unsigned SLOT_W    = $clog2(FRAME_BITS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              cancel_i,
  output logic              run_o,
  output logic              mdc_o,
  output logic              rise_o,
  output logic              slot_end_o,
  output logic              last_o,
  output logic [SLOT_W-1:0] slot_o
);
  localparam int unsigned DIV_W = $clog2(2 * HALF_DIV);
  localparam logic [DIV_W-1:0]  RISE_AT   = DIV_W'(HALF_DIV - 1);
  localparam logic [DIV_W-1:0]  END_AT    = DIV_W'(2 * HALF_DIV - 1);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(FRAME_BITS - 1);

  logic              run_q, mdc_q;
  logic [DIV_W-1:0]  div_q;
  logic [SLOT_W-1:0] slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      mdc_q  <= 1'b0;
      div_q  <= '0;
      slot_q <= '0;
    end else if (start_i) begin
      run_q  <= 1'b1;
      mdc_q  <= 1'b0;
      div_q  <= '0;
      slot_q <= '0;
    end else if (cancel_i) begin
      run_q  <= 1'b0;
      mdc_q  <= 1'b0;
      div_q  <= '0;
      slot_q <= '0;
    end else if (run_q) begin
      if (div_q == END_AT) begin
        div_q <= '0;
        mdc_q <= 1'b0;
        if (slot_q == LAST_SLOT) run_q  <= 1'b0;
        else                     slot_q <= slot_q + 1'b1;
      end else begin
        div_q <= div_q + 1'b1;
        if (div_q == RISE_AT) mdc_q <= 1'b1;
      end
    end
  end

  assign run_o      = run_q;
  assign mdc_o      = mdc_q;
  assign slot_o     = slot_q;
  assign rise_o     = run_q && (div_q == RISE_AT);
  assign slot_end_o = run_q && (div_q == END_AT);
  assign last_o     = slot_end_o && (slot_q == LAST_SLOT);

  a_r6_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |-> !mdc_q);
  a_r6_rise_point: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mdc_q) |-> ($past(div_q) == RISE_AT));
endmodule

// File: rtl/mdio_frame_shift.sv
module mdio_frame_shift
  import mdio_cmd_pkg::*;
#(
  parameter int unsigned PRE_LEN     = 32,
  localparam int unsigned FRAME_BITS = PRE_LEN + FIXED_BITS,
  localparam int unsigned SLOT_W     = $clog2(FRAME_BITS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  mdio_cmd_t         start_cmd_i,
  input  logic              cancel_i,
  input  logic              clear_i,
  input  logic              slot_end_i,
  input  logic              last_i,
  input  logic              rise_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic              rx_i,
  output logic              tx_o,
  output logic              oe_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              done_o
);
  localparam int unsigned RELEASE_BITS = DATA_W + 2;
  localparam int unsigned RX_FROM      = FRAME_BITS - DATA_W;

  logic [FRAME_BITS-1:0] tx_sh, oe_sh, frame_w, mask_w;
  logic [DATA_W-1:0]     rx_sh, rdata_q, dat_w;
  logic [1:0]            ta_w;
  mdio_op_e              op_w;
  logic                  rd_q, done_q;

  always_comb begin
    // read wins when both request flags are set
    op_w    = start_cmd_i.rd ? OP_READ : OP_WRITE;
    ta_w    = start_cmd_i.rd ? 2'b11 : 2'b10;
    dat_w   = start_cmd_i.rd ? '1 : start_cmd_i.wdata;
    frame_w = {{PRE_LEN{1'b1}}, 2'b01, op_w, start_cmd_i.phy, start_cmd_i.regad, ta_w, dat_w};
    mask_w  = start_cmd_i.rd ? {{(FRAME_BITS - RELEASE_BITS){1'b1}}, {RELEASE_BITS{1'b0}}} : '1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_sh   <= '0;
      oe_sh   <= '0;
      rx_sh   <= '0;
      rdata_q <= '0;
      rd_q    <= 1'b0;
      done_q  <= 1'b0;
    end else if (start_i) begin
      tx_sh  <= frame_w;
      oe_sh  <= mask_w;
      rd_q   <= start_cmd_i.rd;
      done_q <= 1'b0;
    end else if (cancel_i) begin
      tx_sh  <= '0;
      oe_sh  <= '0;
      done_q <= 1'b0;
    end else begin
      if (clear_i) done_q <= 1'b0;
      if (rise_i && slot_i >= SLOT_W'(RX_FROM)) rx_sh <= {rx_sh[DATA_W-2:0], rx_i};
      if (slot_end_i) begin
        if (last_i) begin
          tx_sh  <= '0;
          oe_sh  <= '0;
          done_q <= 1'b1;
          if (rd_q) rdata_q <= rx_sh;
        end else begin
          tx_sh <= {tx_sh[FRAME_BITS-2:0], 1'b0};
          oe_sh <= {oe_sh[FRAME_BITS-2:0], 1'b0};
        end
      end
    end
  end

  assign tx_o    = tx_sh[FRAME_BITS-1];
  assign oe_o    = oe_sh[FRAME_BITS-1];
  assign rdata_o = rdata_q;
  assign done_o  = done_q;

  a_r11_write_keeps_rdata: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_i && !rd_q) |=> $stable(rdata_o));
  a_r5_read_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_q && slot_i >= SLOT_W'(FRAME_BITS - RELEASE_BITS)) |-> !oe_o);
endmodule

// File: rtl/mdio_bus_port.sv
module mdio_bus_port #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic act_i,
  input  logic mdc_i,
  input  logic tx_i,
  input  logic oe_i,
  output logic mdc_o,
  output logic mdio_o,
  output logic mdio_oe_o,
  input  logic mdio_i,
  output logic rx_o
);
  logic [SYNC_STAGES-1:0] sync_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= mdio_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= {sync_q[SYNC_STAGES-2:0], mdio_i};
      end
    end
  endgenerate

  assign rx_o      = sync_q[SYNC_STAGES-1];
  assign mdc_o     = mdc_i && act_i;
  assign mdio_oe_o = oe_i && act_i;
  assign mdio_o    = tx_i && mdio_oe_o;
endmodule

// File: rtl/mdio_cmd_ctrl.sv
module mdio_cmd_ctrl
  import mdio_cmd_pkg::*;
#(
  parameter int unsigned HALF_DIV    = 20,
  parameter int unsigned PRE_LEN     = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_we_i,
  input  logic [CMD_W-1:0]  cmd_wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              int_mdc_o,
  output logic              int_mdio_o,
  output logic              int_mdio_oe_o,
  input  logic              int_mdio_i,
  output logic              ext_mdc_o,
  output logic              ext_mdio_o,
  output logic              ext_mdio_oe_o,
  input  logic              ext_mdio_i
);
  localparam int unsigned FRAME_BITS = PRE_LEN + FIXED_BITS;
  localparam int unsigned SLOT_W     = $clog2(FRAME_BITS);

  logic              start, cancel, clear;
  logic              run, mdc, rise, slot_end, last, tx, oe, rx_sel;
  logic [SLOT_W-1:0] slot;
  mdio_cmd_t         start_cmd, cur_cmd;
  logic [NUM_BUS-1:0] act, bus_mdc, bus_mdo, bus_oe, bus_mdi, bus_rx;

  mdio_cmd_reg u_cmd (
    .clk_i, .rst_ni,
    .we_i        (cmd_we_i),
    .wdata_i     (cmd_wdata_i),
    .busy_i      (run),
    .start_o     (start),
    .cancel_o    (cancel),
    .clear_o     (clear),
    .start_cmd_o (start_cmd),
    .cur_cmd_o   (cur_cmd)
  );

  mdio_mdc_gen #(.HALF_DIV(HALF_DIV), .FRAME_BITS(FRAME_BITS)) u_mdc (
    .clk_i, .rst_ni,
    .start_i    (start),
    .cancel_i   (cancel),
    .run_o      (run),
    .mdc_o      (mdc),
    .rise_o     (rise),
    .slot_end_o (slot_end),
    .last_o     (last),
    .slot_o     (slot)
  );

  mdio_frame_shift #(.PRE_LEN(PRE_LEN)) u_shift (
    .clk_i, .rst_ni,
    .start_i     (start),
    .start_cmd_i (start_cmd),
    .cancel_i    (cancel),
    .clear_i     (clear),
    .slot_end_i  (slot_end),
    .last_i      (last),
    .rise_i      (rise),
    .slot_i      (slot),
    .rx_i        (rx_sel),
    .tx_o        (tx),
    .oe_o        (oe),
    .rdata_o     (rdata_o),
    .done_o      (done_o)
  );

  assign bus_mdi = {ext_mdio_i, int_mdio_i};

  generate
    for (genvar g = 0; g < NUM_BUS; g++) begin : g_bus
      assign act[g] = run && (cur_cmd.ext == 1'(g));
      mdio_bus_port #(.SYNC_STAGES(SYNC_STAGES)) u_port (
        .clk_i, .rst_ni,
        .act_i     (act[g]),
        .mdc_i     (mdc),
        .tx_i      (tx),
        .oe_i      (oe),
        .mdc_o     (bus_mdc[g]),
        .mdio_o    (bus_mdo[g]),
        .mdio_oe_o (bus_oe[g]),
        .mdio_i    (bus_mdi[g]),
        .rx_o      (bus_rx[g])
      );
    end
  endgenerate

  assign rx_sel        = bus_rx[cur_cmd.ext];
  assign busy_o        = run;
  assign int_mdc_o     = bus_mdc[0];
  assign int_mdio_o    = bus_mdo[0];
  assign int_mdio_oe_o = bus_oe[0];
  assign ext_mdc_o     = bus_mdc[1];
  assign ext_mdio_o    = bus_mdo[1];
  assign ext_mdio_oe_o = bus_oe[1];

  a_r4_cancel_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && cmd_wdata_i == '0 && busy_o) |=>
      (!busy_o && !done_o && !int_mdc_o && !ext_mdc_o && !int_mdio_oe_o && !ext_mdio_oe_o));
  a_r9_done_after_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy_o) && !$past(cancel)) |-> done_o);
  a_r12_no_flag_no_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && cmd_wdata_i != '0 && !cmd_wdata_i[RD_BIT] && !cmd_wdata_i[WR_BIT] && !busy_o)
      |=> !busy_o);
  a_r10_inactive_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cur_cmd.ext) |-> (!int_mdc_o && !int_mdio_oe_o));
  a_r5_tx_stable_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mdc && $past(mdc)) |-> $stable(tx));
endmodule

// File: tb/mdio_cmd_ctrl_bench.sv
module mdio_cmd_ctrl_bench;
  localparam int HALF       = 20;
  localparam int NBITS      = 64;
  localparam int FRAME_CLKS = 2 * HALF * NBITS;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [31:0] wd = '0;
  logic        busy, done;
  logic [15:0] rdata;
  logic        i_mdc, i_mdo, i_oe, i_mdi;
  logic        e_mdc, e_mdo, e_oe, e_mdi;

  int n_tests = 0;
  int n_fail  = 0;

  bit          phy_bus = 1'b0;
  bit          phy_en  = 1'b0;
  logic [15:0] phy_data = '0;
  logic        phy_drv = 1'b0;
  logic        phy_bit = 1'b1;

  int          rises_i = 0, rises_e = 0;
  logic [63:0] cap_iv, cap_io, cap_ev, cap_eo;
  bit          oe_seen_i = 0, oe_seen_e = 0;
  int          bcnt = 0, hi_cnt = 0, hi_last = 0;
  logic [15:0] exp_rd = '0;

  always #2 clk = ~clk;

  mdio_cmd_ctrl u_mdio_cmd_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_we_i(we), .cmd_wdata_i(wd),
    .busy_o(busy), .done_o(done), .rdata_o(rdata),
    .int_mdc_o(i_mdc), .int_mdio_o(i_mdo), .int_mdio_oe_o(i_oe), .int_mdio_i(i_mdi),
    .ext_mdc_o(e_mdc), .ext_mdio_o(e_mdo), .ext_mdio_oe_o(e_oe), .ext_mdio_i(e_mdi)
  );

  // pulled-up lines with a behavioural PHY on the selected pair
  assign i_mdi = i_oe ? i_mdo : ((!phy_bus && phy_drv) ? phy_bit : 1'b1);
  assign e_mdi = e_oe ? e_mdo : (( phy_bus && phy_drv) ? phy_bit : 1'b1);

  always @(posedge i_mdc) begin
    if (rises_i < NBITS) begin
      cap_iv[63-rises_i] = i_mdo;
      cap_io[63-rises_i] = i_oe;
    end
    rises_i++;
  end
  always @(posedge e_mdc) begin
    if (rises_e < NBITS) begin
      cap_ev[63-rises_e] = e_mdo;
      cap_eo[63-rises_e] = e_oe;
    end
    rises_e++;
  end

  task automatic phy_update(input int k);
    #1;
    if (phy_en && k >= 47 && k <= 63) begin
      phy_drv = 1'b1;
      if (k == 47) phy_bit = 1'b0;
      else         phy_bit = phy_data[63-k];
    end else begin
      phy_drv = 1'b0;
    end
  endtask

  always @(negedge i_mdc) if (!phy_bus) phy_update(rises_i);
  always @(negedge e_mdc) if (phy_bus)  phy_update(rises_e);

  always @(negedge clk) begin
    if (i_oe) oe_seen_i = 1;
    if (e_oe) oe_seen_e = 1;
    if (busy) bcnt++;
    if (i_mdc || e_mdc) hi_cnt++;
    else begin
      if (hi_cnt != 0) hi_last = hi_cnt;
      hi_cnt = 0;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clr_cap();
    rises_i = 0; rises_e = 0;
    cap_iv = '0; cap_io = '0; cap_ev = '0; cap_eo = '0;
    oe_seen_i = 0; oe_seen_e = 0;
    bcnt = 0; phy_drv = 1'b0;
  endtask

  task automatic wr(input logic [31:0] w);
    @(negedge clk);
    we = 1'b1; wd = w;
    @(negedge clk);
    we = 1'b0; wd = '0;
  endtask

  function automatic logic [31:0] mk(input bit rd, input bit wrf, input bit ext,
                                     input logic [4:0] phy, input logic [4:0] rg,
                                     input logic [15:0] d);
    logic [31:0] w;
    w = '0;
    w[31] = rd; w[30] = wrf; w[26] = ext;
    w[25:21] = phy; w[20:16] = rg; w[15:0] = d;
    return w;
  endfunction

  function automatic logic [63:0] exp_frame(input logic [31:0] w);
    bit rd;
    rd = w[31];
    return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), w[25:21], w[20:16],
            (rd ? 2'b11 : 2'b10), (rd ? 16'hFFFF : w[15:0])};
  endfunction

  function automatic logic [63:0] exp_mask(input logic [31:0] w);
    return w[31] ? {{46{1'b1}}, 18'b0} : {64{1'b1}};
  endfunction

  task automatic run_frame(input logic [31:0] w, input bit phy_on,
                           input logic [15:0] pdat, input logic [31:0] intf);
    bit ext;
    logic [63:0] m;
    ext = w[26];
    m = exp_mask(w);
    clr_cap();
    phy_bus = ext; phy_en = phy_on; phy_data = pdat;
    wr(32'h0);
    chk("R9 done cleared by zero write", 64'(done), 64'd0);
    wr(w);
    chk("R2 busy after accepted command", 64'(busy), 64'd1);
    if (intf != 0) begin
      repeat (300) @(negedge clk);
      wr(intf);
    end
    while (busy) @(negedge clk);
    if (w[31]) exp_rd = phy_on ? pdat : 16'hFFFF;
    chk("R8 busy length", 64'(bcnt), 64'(FRAME_CLKS));
    chk("R6 rising edges per frame", 64'(ext ? rises_e : rises_i), 64'(NBITS));
    chk("R6 clock high width", 64'(hi_last), 64'(HALF));
    chk("R5 frame bits", (ext ? cap_ev : cap_iv) & m, exp_frame(w) & m);
    chk("R5 drive enables", ext ? cap_eo : cap_io, m);
    chk("R10 inactive pair quiet", 64'({(ext ? rises_i : rises_e) != 0, ext ? oe_seen_i : oe_seen_e}), 64'd0);
    chk("R9 done after frame", 64'(done), 64'd1);
    chk(w[31] ? "R7 read data" : "R11 write keeps read data", 64'(rdata), 64'(exp_rd));
  endtask

  bit finished = 0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int seed;
    int r0;
    seed = 7;
    r0 = $urandom(seed);
    repeat (5) @(negedge clk);
    // R1 reset state
    chk("R1 busy", 64'(busy), 0);
    chk("R1 done", 64'(done), 0);
    chk("R1 rdata", 64'(rdata), 0);
    chk("R1 clocks", 64'({i_mdc, e_mdc}), 0);
    chk("R1 enables", 64'({i_oe, e_oe}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2 R5 R7 read on internal pair
    run_frame(mk(1, 0, 0, 5'h11, 5'h02, 16'h0), 1, 16'hA5C3, 0);
    // R10 R11 write on external pair
    run_frame(mk(0, 1, 1, 5'h1F, 5'h15, 16'h1234), 0, 16'h0, 0);
    // R7 undriven read returns all ones
    run_frame(mk(1, 0, 1, 5'h03, 5'h01, 16'h0), 0, 16'h0, 0);
    // R2 both flags set: read wins
    run_frame(mk(1, 1, 0, 5'h0A, 5'h1E, 16'hBEEF), 1, 16'h0F0F, 0);

    // R3 non-zero write with register still holding a command
    clr_cap();
    wr(mk(0, 1, 0, 5'h01, 5'h01, 16'h5555));
    repeat (50) @(negedge clk);
    chk("R3 no rearm without zero write", 64'({busy, rises_i != 0}), 0);

    // R3 command written in mid-frame is ignored
    run_frame(mk(0, 1, 0, 5'h06, 5'h09, 16'hC001), 0, 16'h0, mk(1, 0, 1, 5'h1F, 5'h1F, 16'h0));

    // R4 abort by zero write
    clr_cap();
    phy_bus = 0; phy_en = 1; phy_data = 16'h1357;
    wr(32'h0);
    wr(mk(1, 0, 0, 5'h04, 5'h07, 16'h0));
    repeat (600) @(negedge clk);
    wr(32'h0);
    chk("R4 busy low after abort", 64'(busy), 0);
    chk("R4 pins quiet after abort", 64'({i_mdc, i_oe, e_mdc, e_oe}), 0);
    chk("R4 done low after abort", 64'(done), 0);
    chk("R4 rdata kept after abort", 64'(rdata), 64'(exp_rd));
    begin
      int r_saved;
      r_saved = rises_i;
      repeat (200) @(negedge clk);
      chk("R4 no edges after abort", 64'(rises_i), 64'(r_saved));
    end
    run_frame(mk(1, 0, 0, 5'h04, 5'h07, 16'h0), 1, 16'h2468, 0);

    // R12 word without request flags
    clr_cap();
    wr(32'h0);
    wr(32'h0123_4567);
    repeat (50) @(negedge clk);
    chk("R12 no frame for flagless word", 64'({busy, rises_i != 0, rises_e != 0}), 0);
    wr(mk(1, 0, 0, 5'h02, 5'h02, 16'h0));
    repeat (50) @(negedge clk);
    chk("R12 stored word blocks next command", 64'({busy, rises_i != 0}), 0);

    // random traffic
    for (int t = 0; t < 6; t++) begin
      bit rd, ext, pon;
      logic [31:0] w;
      rd  = 1'($urandom);
      ext = 1'($urandom);
      pon = 1'($urandom);
      w = mk(rd, !rd, ext, 5'($urandom), 5'($urandom), 16'($urandom));
      run_frame(w, pon, 16'($urandom), 0);
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule